// File: doc/BRIEF.md
# Bus-Attached Bitwise-AND Register Slave

This block is a zero-wait-state slave on an AMBA AHB system bus. It holds a set of 32-bit operand registers, two by default, that a bus master fills with word writes. A word read at the base of its address window returns the bitwise AND of all operands. The AND is formed combinationally from the stored operands, not kept as a register of its own. The operands can also be read back at their own offsets.

The slave accepts a transfer in the address phase: the decoder's select and the bus ready must be high, the transfer type must be NONSEQ or SEQ, the size must be a word, and the address must be word-aligned and inside the window. It registers the transfer kind and the word index. In the following data phase it loads the write data into the addressed operand, or it drives the read data. Pipelined back-to-back transfers and incrementing bursts are handled one word beat at a time.

Top module: `ahbsand_top`

## Requirements
- R1: After reset every operand register is 0, so a read of offset 0x0 returns 0x00000000.
- R2: An accepted word write to offset 0x4 (address 0xB0000004) loads operand A from the write data bus in the data phase. A later read of 0x4 returns that value.
- R3: An accepted word write to offset 0x8 (address 0xB0000008) loads operand B. A later read of 0x8 returns that value.
- R4: A read of offset 0x0 (address 0xB0000000) returns the bitwise AND of the operands in the data phase that follows its address phase. For example, 0x11111000 and 0x00001111 give 0x00001000. NONSEQ (trans 2) and SEQ (trans 3) beats are treated alike.
- R5: Address phases with trans IDLE (0) or BUSY (1) change no operand and return read data 0.
- R6: With select low, a transfer changes no operand.
- R7: Only size code 2 (32-bit word) is acted on. A write with any other size leaves the operands unchanged.
- R8: A write to offset 0x0 or to any unused offset changes no operand. A read of an unused offset returns 0, and the read data is 0 in every data phase that is not a read of a mapped offset.
- R9: The ready output is always 1 and the response is always OKAY (2'b00).
- R10: A transfer whose address is outside the 256-byte window at 0xB0000000 is ignored, even with select high.
- R11: A read of 0x0 whose address phase coincides with the data phase of a write sees the newly written operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Slave select from the bus decoder |
| addr_i | input | 32 | Transfer address |
| trans_i | input | 2 | Transfer type: 0 IDLE, 1 BUSY, 2 NONSEQ, 3 SEQ |
| write_i | input | 1 | 1 for write, 0 for read |
| size_i | input | 3 | Transfer size code, 2 for a word |
| ready_in_i | input | 1 | Bus ready, marks a valid address phase |
| wdata_i | input | 32 | Write data, valid in the data phase |
| rdata_o | output | 32 | Read data, valid in the data phase |
| ready_o | output | 1 | Transfer done, tied high |
| resp_o | output | 2 | Transfer response, always OKAY |

## Verification
The assertions check four things on every cycle: that ready stays high and the response stays OKAY, that an operand holds its value unless a qualifying write to it was accepted one address phase earlier, and that the read data equals the operand AND whenever a read of offset 0x0 is in its data phase. Read data of zero outside mapped reads is checked the same way. Three things can only be shown by the bench's scenarios: the exact values loaded by writes, the rejection of off-window addresses and wrong sizes as seen at the read port, and the forwarding of a write into an immediately following read.

// File: rtl/ahbsand_pkg.sv
package ahbsand_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 32;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'd0,
    TR_BUSY   = 2'd1,
    TR_NONSEQ = 2'd2,
    TR_SEQ    = 2'd3
  } trans_e;

  localparam logic [2:0] SIZE_WORD = 3'd2;
  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/ahbsand_rst_sync.sv
module ahbsand_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/ahbsand_addr_stage.sv
module ahbsand_addr_stage #(
  parameter int                      ADDR_W   = 32,
  parameter int                      WIN_BITS = 8,
  parameter logic [ADDR_W-1:0]       BASE     = 32'hB000_0000,
  localparam int                     IDX_W    = WIN_BITS - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        trans_i,
  input  logic              write_i,
  input  logic [2:0]        size_i,
  input  logic              ready_in_i,
  output logic              dp_valid_o,
  output logic              dp_write_o,
  output logic [IDX_W-1:0]  dp_idx_o
);
  import ahbsand_pkg::*;

  logic             in_window;
  logic             aligned;
  logic             active;
  logic             accept;
  logic             valid_d, valid_q;
  logic             write_d, write_q;
  logic [IDX_W-1:0] idx_d,   idx_q;

  always_comb begin
    in_window = (addr_i[ADDR_W-1:WIN_BITS] == BASE[ADDR_W-1:WIN_BITS]);
    aligned   = (addr_i[1:0] == 2'b00);
    active    = (trans_i == TR_NONSEQ) || (trans_i == TR_SEQ);
    accept    = sel_i && ready_in_i && active && (size_i == SIZE_WORD)
                && in_window && aligned;
  end

  always_comb begin
    valid_d = valid_q;
    write_d = write_q;
    idx_d   = idx_q;
    if (ready_in_i) begin
      valid_d = accept;
      write_d = accept && write_i;
      idx_d   = accept ? addr_i[WIN_BITS-1:2] : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      write_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      valid_q <= valid_d;
      write_q <= write_d;
      idx_q   <= idx_d;
    end
  end

  assign dp_valid_o = valid_q;
  assign dp_write_o = write_q;
  assign dp_idx_o   = idx_q;
endmodule

// File: rtl/ahbsand_opregs.sv
module ahbsand_opregs #(
  parameter int  DATA_W  = 32,
  parameter int  NUM_OPS = 2,
  parameter int  IDX_W   = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           dp_valid_i,
  input  logic                           dp_write_i,
  input  logic [IDX_W-1:0]               dp_idx_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [NUM_OPS-1:0][DATA_W-1:0] ops_o
);
  for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
    logic              wen;
    logic [DATA_W-1:0] op_d, op_q;

    always_comb begin
      wen  = dp_valid_i && dp_write_i && (dp_idx_i == IDX_W'(i + 1));
      op_d = wen ? wdata_i : op_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) op_q <= '0;
      else        op_q <= op_d;
    end

    assign ops_o[i] = op_q;
  end
endmodule

// File: rtl/ahbsand_rdmux.sv
module ahbsand_rdmux #(
  parameter int  DATA_W  = 32,
  parameter int  NUM_OPS = 2,
  parameter int  IDX_W   = 6
) (
  input  logic                           dp_valid_i,
  input  logic                           dp_write_i,
  input  logic [IDX_W-1:0]               dp_idx_i,
  input  logic [NUM_OPS-1:0][DATA_W-1:0] ops_i,
  output logic [DATA_W-1:0]              rdata_o
);
  logic [DATA_W-1:0] and_all;
  logic [DATA_W-1:0] sel_op;

  always_comb begin
    and_all = '1;
    sel_op  = '0;
    for (int i = 0; i < NUM_OPS; i++) begin
      and_all = and_all & ops_i[i];
      if (dp_idx_i == IDX_W'(i + 1)) sel_op = ops_i[i];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (dp_valid_i && !dp_write_i) begin
      if (dp_idx_i == '0) rdata_o = and_all;
      else                rdata_o = sel_op;
    end
  end
endmodule

// File: rtl/ahbsand_top.sv
module ahbsand_top #(
  parameter int          NUM_OPS  = 2,
  parameter int          WIN_BITS = 8,
  parameter logic [31:0] BASE     = 32'hB000_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_i,
  input  logic [31:0] addr_i,
  input  logic [1:0]  trans_i,
  input  logic        write_i,
  input  logic [2:0]  size_i,
  input  logic        ready_in_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        ready_o,
  output logic [1:0]  resp_o
);
  import ahbsand_pkg::*;

  localparam int IDX_W = WIN_BITS - 2;

  logic                           rst_sync_n;
  logic                           dp_valid;
  logic                           dp_write;
  logic [IDX_W-1:0]               dp_idx;
  logic [NUM_OPS-1:0][DATA_W-1:0] ops;

  ahbsand_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ahbsand_addr_stage #(
    .ADDR_W   (ADDR_W),
    .WIN_BITS (WIN_BITS),
    .BASE     (BASE)
  ) u_addr (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sel_i      (sel_i),
    .addr_i     (addr_i),
    .trans_i    (trans_i),
    .write_i    (write_i),
    .size_i     (size_i),
    .ready_in_i (ready_in_i),
    .dp_valid_o (dp_valid),
    .dp_write_o (dp_write),
    .dp_idx_o   (dp_idx)
  );

  ahbsand_opregs #(
    .DATA_W  (DATA_W),
    .NUM_OPS (NUM_OPS),
    .IDX_W   (IDX_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .dp_valid_i (dp_valid),
    .dp_write_i (dp_write),
    .dp_idx_i   (dp_idx),
    .wdata_i    (wdata_i),
    .ops_o      (ops)
  );

  ahbsand_rdmux #(
    .DATA_W  (DATA_W),
    .NUM_OPS (NUM_OPS),
    .IDX_W   (IDX_W)
  ) u_rd (
    .dp_valid_i (dp_valid),
    .dp_write_i (dp_write),
    .dp_idx_i   (dp_idx),
    .ops_i      (ops),
    .rdata_o    (rdata_o)
  );

  assign ready_o = 1'b1;
  assign resp_o  = RESP_OKAY;
endmodule

// File: rtl/ahbsand_chk.sv
module ahbsand_chk #(
  parameter int          NUM_OPS  = 2,
  parameter int          WIN_BITS = 8,
  parameter logic [31:0] BASE     = 32'hB000_0000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sel_i,
  input  logic [31:0]                addr_i,
  input  logic [1:0]                 trans_i,
  input  logic                       write_i,
  input  logic [2:0]                 size_i,
  input  logic                       ready_in_i,
  input  logic [31:0]                rdata_o,
  input  logic                       ready_o,
  input  logic [1:0]                 resp_o,
  input  logic [NUM_OPS-1:0][31:0]   ops
);
  localparam int IDX_W = WIN_BITS - 2;

  logic               take;
  logic [IDX_W-1:0]   widx;
  logic [NUM_OPS-1:0] pend_wr;
  logic               pend_rd0;
  logic               pend_rd_map;
  logic [31:0]        and_ops;

  always_comb begin
    take = sel_i && ready_in_i && trans_i[1] && (size_i == 3'd2)
           && (addr_i[31:WIN_BITS] == BASE[31:WIN_BITS]) && (addr_i[1:0] == 2'b00);
    widx = addr_i[WIN_BITS-1:2];
    and_ops = '1;
    for (int i = 0; i < NUM_OPS; i++) and_ops = and_ops & ops[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_wr     <= '0;
      pend_rd0    <= 1'b0;
      pend_rd_map <= 1'b0;
    end else if (ready_in_i) begin
      for (int i = 0; i < NUM_OPS; i++)
        pend_wr[i] <= take && write_i && (widx == IDX_W'(i + 1));
      pend_rd0    <= take && !write_i && (widx == '0);
      pend_rd_map <= take && !write_i && (int'(widx) <= NUM_OPS);
    end
  end

  assert_ready_high_R9: assert property (@(posedge clk) disable iff (!rst_n) ready_o == 1'b1);
  assert_resp_okay_R9:  assert property (@(posedge clk) disable iff (!rst_n) resp_o == 2'b00);

  assert_and_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_rd0 |-> (rdata_o == and_ops));

  assert_quiet_rdata_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_rd_map |-> (rdata_o == 32'h0));

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_hold
    // Covers R5, R6, R7, R8 and R10: no accepted write, no operand change
    assert_op_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_wr[i] |=> $stable(ops[i]));
  end
endmodule

bind ahbsand_top ahbsand_chk #(
  .NUM_OPS  (NUM_OPS),
  .WIN_BITS (WIN_BITS),
  .BASE     (BASE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .sel_i      (sel_i),
  .addr_i     (addr_i),
  .trans_i    (trans_i),
  .write_i    (write_i),
  .size_i     (size_i),
  .ready_in_i (ready_in_i),
  .rdata_o    (rdata_o),
  .ready_o    (ready_o),
  .resp_o     (resp_o),
  .ops        (ops)
);

// File: tb/sim_ahbsand_top.sv
`timescale 1ns/1ps
module sim_ahbsand_top;
  logic        clk;
  logic        rst_n;
  logic        sel_i;
  logic [31:0] addr_i;
  logic [1:0]  trans_i;
  logic        write_i;
  logic [2:0]  size_i;
  logic        ready_in_i;
  logic [31:0] wdata_i;
  logic [31:0] rdata_o;
  logic        ready_o;
  logic [1:0]  resp_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] rd;

  localparam logic [31:0] BASE = 32'hB000_0000;

  ahbsand_top u0 (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {wr, trans[1:0], size[2:0], offset[7:0], wdata[31:0], expected[31:0]}
  localparam int NV = 17;
  localparam logic [77:0] VEC [0:NV-1] = '{
    {1'b0, 2'd2, 3'd2, 8'h00, 32'h0,          32'h0000_0000}, // R1
    {1'b1, 2'd2, 3'd2, 8'h04, 32'h1111_1000,  32'h0},         // R2
    {1'b1, 2'd2, 3'd2, 8'h08, 32'h0000_1111,  32'h0},         // R3
    {1'b0, 2'd2, 3'd2, 8'h00, 32'h0,          32'h0000_1000}, // R4
    {1'b0, 2'd2, 3'd2, 8'h04, 32'h0,          32'h1111_1000}, // R2
    {1'b0, 2'd3, 3'd2, 8'h08, 32'h0,          32'h0000_1111}, // R3
    {1'b1, 2'd2, 3'd1, 8'h04, 32'hFFFF_FFFF,  32'h0},         // R7
    {1'b0, 2'd2, 3'd2, 8'h04, 32'h0,          32'h1111_1000}, // R7
    {1'b1, 2'd1, 3'd2, 8'h08, 32'h0,          32'h0},         // R5
    {1'b0, 2'd2, 3'd2, 8'h08, 32'h0,          32'h0000_1111}, // R5
    {1'b1, 2'd2, 3'd2, 8'h00, 32'hDEAD_BEEF,  32'h0},         // R8
    {1'b0, 2'd2, 3'd2, 8'h00, 32'h0,          32'h0000_1000}, // R8
    {1'b1, 2'd2, 3'd2, 8'h0C, 32'hAAAA_5555,  32'h0},         // R8
    {1'b0, 2'd2, 3'd2, 8'h0C, 32'h0,          32'h0000_0000}, // R8
    {1'b1, 2'd2, 3'd2, 8'h04, 32'hF0F0_F0F0,  32'h0},         // R2
    {1'b1, 2'd3, 3'd2, 8'h08, 32'hFFFF_0000,  32'h0},         // R3
    {1'b0, 2'd3, 3'd2, 8'h00, 32'h0,          32'hF0F0_0000}  // R4
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic idle_bus();
    sel_i = 1'b0; trans_i = 2'd0; write_i = 1'b0; size_i = 3'd2; addr_i = '0;
  endtask

  // One transfer: address phase, then data phase; read data sampled mid data phase
  task automatic xfer(input logic s, input logic w, input logic [1:0] tr,
                      input logic [2:0] sz, input logic [31:0] a,
                      input logic [31:0] wd, output logic [31:0] r);
    @(negedge clk);
    sel_i = s; write_i = w; trans_i = tr; size_i = sz; addr_i = a;
    @(posedge clk);
    #1;
    idle_bus();
    wdata_i = wd;
    @(negedge clk);
    r = rdata_o;
    check("R9 ready", {31'd0, ready_o}, 32'd1);
    check("R9 resp", {30'd0, resp_o}, 32'd0);
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    ready_in_i = 1'b1;
    wdata_i = '0;
    idle_bus();
    do_reset();

    for (int i = 0; i < NV; i++) begin
      xfer(1'b1, VEC[i][77], VEC[i][76:75], VEC[i][74:72],
           BASE + {24'd0, VEC[i][71:64]}, VEC[i][63:32], rd);
      if (!VEC[i][77]) check($sformatf("vector %0d R1-R8 read", i), rd, VEC[i][31:0]);
    end

    // R6: select low write to operand A ignored
    xfer(1'b0, 1'b1, 2'd2, 3'd2, BASE + 32'h4, 32'h0000_0000, rd);
    xfer(1'b1, 1'b0, 2'd2, 3'd2, BASE + 32'h4, 32'h0, rd);
    check("R6 sel low", rd, 32'hF0F0_F0F0);

    // R10: address outside the window ignored
    xfer(1'b1, 1'b1, 2'd2, 3'd2, 32'hB000_0104, 32'h1234_5678, rd);
    xfer(1'b1, 1'b0, 2'd2, 3'd2, BASE + 32'h4, 32'h0, rd);
    check("R10 off window", rd, 32'hF0F0_F0F0);

    // R11: write A then read 0x0 in the very next address phase
    @(negedge clk);
    sel_i = 1'b1; write_i = 1'b1; trans_i = 2'd2; size_i = 3'd2; addr_i = BASE + 32'h4;
    @(posedge clk);
    #1;
    wdata_i = 32'h0FF0_0FF0;
    write_i = 1'b0; trans_i = 2'd3; addr_i = BASE;
    @(posedge clk);
    #1;
    idle_bus();
    @(negedge clk);
    check("R11 forward", rdata_o, 32'h0FF0_0000);
    @(posedge clk);
    #1;

    // R1: reset in the middle clears the operands
    do_reset();
    xfer(1'b1, 1'b0, 2'd2, 3'd2, BASE + 32'h8, 32'h0, rd);
    check("R1 op B after reset", rd, 32'h0);
    xfer(1'b1, 1'b0, 2'd2, 3'd2, BASE, 32'h0, rd);
    check("R1 and after reset", rd, 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule